// File: doc/BRIEF.md
# Dual-Rail Precharged Datapath with Forbidden-Code Alarm

This block computes a bitwise function of two single-rail operands while every logical bit inside it is carried as a pair of complementary rails. A small controller splits time into alternating precharge and evaluate clocks. During precharge, a spacer stage placed after each register drives every rail pair to the empty code. The spacer then ripples through the dual-rail gates, so no separate precharge signal reaches them. During evaluate, each pair moves once from the spacer to a valid code. Every pair therefore switches once per two clocks, whatever the data value.

The datapath computes `res = ~(op_a & op_b) ^ op_b`. It is built from a dual-rail AND, an inverter made as a rail swap, and a dual-rail XOR. A completion detector watches the gate outputs. The result is reported valid only when every output pair was differential at the capture edge. A per-bit `tamper` input ORs the forbidden code into a gate-output pair, which models a physical disturbance. When the detector sees the forbidden code on any pair, the controller enters a sticky alarm state. That state clears all registers to the spacer and holds them there until reset.

The controller has three states. PRECHARGE (the reset state) moves to EVALUATE. EVALUATE moves back to PRECHARGE. Either of these moves to ALARM when a forbidden code is seen. ALARM holds until reset.

Top module: `drpl_datapath`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `res` is 0, `res_valid` is 0 and `alarm` is 0, and the controller is in PRECHARGE.
- R2: The controller alternates PRECHARGE and EVALUATE on successive clocks. Registers change only on the edge that ends an EVALUATE clock, or when they are cleared. An operand pair sampled on such an edge reaches `res` on the next such edge, two clocks later.
- R3: Rail code is {true, false}. 10 means logic 1, 01 means logic 0, 00 is the spacer and 11 is forbidden. The output register never holds 11.
- R4: When valid, each bit of `res` equals `~(a & b) ^ b`, where a and b are the operand bits that were sampled.
- R5: Outside EVALUATE, with no tamper, every gate-output pair is at the spacer 00.
- R6: `res_valid` is high only when every output pair was differential at capture. The first capture after reset or alarm carries the spacer and gives `res_valid` = 0.
- R7: A forbidden 11 code on any gate-output pair, in either phase, raises `alarm` on the next clock edge.
- R8: `alarm` stays high until `rst`. While it is high, `res` and `res_valid` are 0, even after the fault goes away. After reset, normal operation resumes.
- R9: Operand values present on clocks other than the end of EVALUATE have no effect on `res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one phase |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | Single-rail operand A |
| op_b | input | W | Single-rail operand B |
| tamper | input | W | Per-bit disturbance; forces the gate-output pair to 11 |
| res | output | W | Single-rail result (true rails of the output register) |
| res_valid | output | 1 | All output pairs were differential at capture |
| alarm | output | 1 | Sticky forbidden-code alarm |

## Verification
Two events can fall on the same edge: the end-of-evaluate capture and a forbidden code seen by the detector. The bench raises `tamper` during an EVALUATE clock whose capture edge would otherwise latch a fresh valid result. On that edge the clear must win, so the check expects `alarm` high with `res` and `res_valid` at zero. A tamper raised during PRECHARGE checks the other branch of the controller. A per-clock behavioural model compares every output on every clock through both cases and through reset recovery.

// File: rtl/drpl_pkg.sv
package drpl_pkg;

    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_SPACER = 2'b00;

    typedef enum logic [1:0] {
        ST_PRECHARGE = 2'd0,
        ST_EVALUATE  = 2'd1,
        ST_ALARM     = 2'd2
    } phase_e;

    typedef enum logic {
        GK_AND = 1'b0,
        GK_XOR = 1'b1
    } gate_e;

    function automatic rail_t rail_enc(input logic v);
        return {v, ~v};
    endfunction

    function automatic rail_t rail_not(input rail_t p);
        return {p[0], p[1]};
    endfunction

endpackage

// File: rtl/drpl_gate.sv
module drpl_gate
    import drpl_pkg::*;
#(
    parameter gate_e KIND = GK_AND
) (
    input  rail_t a,
    input  rail_t b,
    output rail_t y
);
    generate
        if (KIND == GK_AND) begin : g_and
            assign y[1] = a[1] & b[1];
            assign y[0] = a[0] | b[0];
        end else begin : g_xor
            assign y[1] = (a[1] & b[0]) | (a[0] & b[1]);
            assign y[0] = (a[1] & b[1]) | (a[0] & b[0]);
        end
    endgenerate
endmodule

// File: rtl/drpl_complete.sv
module drpl_complete #(
    parameter int W = 8
) (
    input  logic [W-1:0][1:0] pairs,
    output logic              all_diff,
    output logic              any_bad
);
    logic [W-1:0] diff_bits;
    logic [W-1:0] bad_bits;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            diff_bits[i] = pairs[i][1] ^ pairs[i][0];
            bad_bits[i]  = pairs[i][1] & pairs[i][0];
        end
        all_diff = &diff_bits;
        any_bad  = |bad_bits;
    end
endmodule

// File: rtl/drpl_phase_ctl.sv
module drpl_phase_ctl
    import drpl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault,
    output logic eval,
    output logic cap,
    output logic clr,
    output logic alarm
);
    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRECHARGE: state_d = fault ? ST_ALARM : ST_EVALUATE;
            ST_EVALUATE:  state_d = fault ? ST_ALARM : ST_PRECHARGE;
            ST_ALARM:     state_d = ST_ALARM;
            default:      state_d = ST_ALARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRECHARGE;
        else     state_q <= state_d;
    end

    always_comb begin
        eval  = 1'b0;
        cap   = 1'b0;
        clr   = fault;
        alarm = 1'b0;
        unique case (state_q)
            ST_PRECHARGE: ;
            ST_EVALUATE: begin
                eval = 1'b1;
                cap  = ~fault;
            end
            ST_ALARM: begin
                clr   = 1'b1;
                alarm = 1'b1;
            end
            default: begin
                clr   = 1'b1;
                alarm = 1'b1;
            end
        endcase
    end

    // R2: precharge is always followed by evaluate unless a fault intervenes
    a_r2_pre_to_eval: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRECHARGE && !fault) |=> (state_q == ST_EVALUATE));

    // R2: evaluate is always followed by precharge unless a fault intervenes
    a_r2_eval_to_pre: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVALUATE && !fault) |=> (state_q == ST_PRECHARGE));

    // R8: alarm state is left only through reset
    a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALARM) |=> (state_q == ST_ALARM));
endmodule

// File: rtl/drpl_datapath.sv
module drpl_datapath
    import drpl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] tamper,
    output logic [W-1:0] res,
    output logic         res_valid,
    output logic         alarm
);
    logic [W-1:0][1:0] a_q, b_q;
    logic [W-1:0][1:0] a_pc, b_pc;
    logic [W-1:0][1:0] and_w, nand_w, z_raw, z;
    logic [W-1:0][1:0] out_q;
    logic [W-1:0]      out_t, out_f;
    logic              valid_q;
    logic              eval, cap, clr, fault, all_diff;

    drpl_phase_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .fault (fault),
        .eval  (eval),
        .cap   (cap),
        .clr   (clr),
        .alarm (alarm)
    );

    // precharge stage after the operand registers
    always_comb begin
        for (int i = 0; i < W; i++) begin
            a_pc[i] = eval ? a_q[i] : RAIL_SPACER;
            b_pc[i] = eval ? b_q[i] : RAIL_SPACER;
        end
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            drpl_gate #(.KIND(GK_AND)) u_and (
                .a (a_pc[i]),
                .b (b_pc[i]),
                .y (and_w[i])
            );
            assign nand_w[i] = rail_not(and_w[i]);
            drpl_gate #(.KIND(GK_XOR)) u_xor (
                .a (nand_w[i]),
                .b (b_pc[i]),
                .y (z_raw[i])
            );
            assign z[i] = z_raw[i] | {2{tamper[i]}};
        end
    endgenerate

    drpl_complete #(.W(W)) u_cd (
        .pairs    (z),
        .all_diff (all_diff),
        .any_bad  (fault)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            a_q     <= '0;
            b_q     <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
        end else if (cap) begin
            for (int i = 0; i < W; i++) begin
                a_q[i] <= rail_enc(op_a[i]);
                b_q[i] <= rail_enc(op_b[i]);
            end
            out_q   <= z;
            valid_q <= all_diff;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out_t[i] = out_q[i][1];
            out_f[i] = out_q[i][0];
        end
    end

    assign res       = out_t;
    assign res_valid = valid_q;

    // R7: a forbidden code seen now raises the alarm on the next edge
    a_r7_alarm_next: assert property (@(posedge clk) disable iff (rst)
        fault |=> alarm);

    // R8: alarm silences the outputs
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        alarm |-> (!res_valid && res == '0));

    // R5: spacer wave reaches every gate output outside evaluate
    a_r5_spacer_wave: assert property (@(posedge clk) disable iff (rst)
        (!eval && tamper == '0) |-> (z == '0));

    // R3: the output register never holds the forbidden code
    a_r3_no_forbidden: assert property (@(posedge clk) disable iff (rst)
        (out_t & out_f) == '0);

    // R6: valid implies every stored pair is differential
    a_r6_valid_diff: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((out_t ^ out_f) == '1));

    // R2: nothing visible changes on the edge that ends precharge
    a_r2_hold_pre: assert property (@(posedge clk) disable iff (rst)
        (!eval && !alarm && !fault) |=> ($stable(res) && $stable(res_valid)));
endmodule

// File: tb/drpl_datapath_test.sv
module drpl_datapath_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] tamper = '0;
    logic [W-1:0] res;
    logic         res_valid;
    logic         alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 1'b0;

    // behavioural model state
    bit           m_eval, m_in_v, m_valid, m_alarm;
    logic [W-1:0] m_a, m_b, m_res;

    drpl_datapath #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .tamper    (tamper),
        .res       (res),
        .res_valid (res_valid),
        .alarm     (alarm)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] ref_fn(input logic [W-1:0] a, input logic [W-1:0] b);
        return ~(a & b) ^ b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_eval = 0; m_in_v = 0; m_valid = 0; m_alarm = 0;
            m_a = '0; m_b = '0; m_res = '0;
        end else if (m_alarm || tamper != '0) begin
            m_alarm = 1; m_eval = 0; m_in_v = 0; m_valid = 0;
            m_a = '0; m_b = '0; m_res = '0;
        end else if (m_eval) begin
            m_res   = m_in_v ? ref_fn(m_a, m_b) : '0;
            m_valid = m_in_v;
            m_a = op_a; m_b = op_b; m_in_v = 1;
            m_eval  = 0;
        end else begin
            m_eval = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock model comparison (R2 R4 R6 R9)
    always @(negedge clk) begin
        if (running && !rst) begin
            check("R2 R4 R9 res", {24'd0, res}, {24'd0, m_res});
            check("R6 res_valid", {31'd0, res_valid}, {31'd0, m_valid});
            check("R7 R8 alarm", {31'd0, alarm}, {31'd0, m_alarm});
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        step(3);
        check("R1 reset res", {24'd0, res}, 32'd0);
        check("R1 reset valid", {31'd0, res_valid}, 32'd0);
        check("R1 reset alarm", {31'd0, alarm}, 32'd0);

        // held operands: first capture carries spacer, second carries data
        op_a = 8'hC3; op_b = 8'hA5;
        rst = 1'b0; running = 1'b1;
        step(1);
        check("R1 first clock valid", {31'd0, res_valid}, 32'd0);
        step(1);
        check("R6 spacer capture", {31'd0, res_valid}, 32'd0);
        step(2);
        check("R6 first result valid", {31'd0, res_valid}, 32'd1);
        check("R4 first result", {24'd0, res}, {24'd0, ref_fn(8'hC3, 8'hA5)});

        // operands changing every clock: only eval-end values matter (R9)
        for (int i = 0; i < 80; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            op_a = lcg[23:16];
            op_b = lcg[15:8];
            step(1);
        end

        // corner patterns
        op_a = '0; op_b = '0; step(4);
        check("R4 zeros", {24'd0, res}, {24'd0, ref_fn('0, '0)});
        op_a = '1; op_b = '1; step(4);
        check("R4 ones", {24'd0, res}, {24'd0, ref_fn('1, '1)});
        op_a = 8'h55; op_b = 8'hAA; step(4);
        check("R4 alternating", {24'd0, res}, {24'd0, ref_fn(8'h55, 8'hAA)});

        // tamper during evaluate while a capture is due (R7 wins over R2)
        while (!(m_eval)) step(1);
        tamper = 8'h10;
        step(1);
        check("R7 alarm after eval tamper", {31'd0, alarm}, 32'd1);
        check("R8 res cleared", {24'd0, res}, 32'd0);
        tamper = '0;
        step(5);
        check("R8 alarm sticky", {31'd0, alarm}, 32'd1);
        check("R8 valid quiet", {31'd0, res_valid}, 32'd0);

        // recovery after reset
        rst = 1'b1; step(2);
        op_a = 8'h0F; op_b = 8'h3C;
        rst = 1'b0; step(4);
        check("R8 recovered alarm", {31'd0, alarm}, 32'd0);
        check("R4 recovered result", {24'd0, res}, {24'd0, ref_fn(8'h0F, 8'h3C)});

        // tamper during precharge
        while (m_eval) step(1);
        tamper = 8'h01;
        step(1);
        check("R7 alarm after precharge tamper", {31'd0, alarm}, 32'd1);
        tamper = '0;
        step(3);

        running = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule